// File: doc/BRIEF.md
# Gated Multi-Ratio Clock Divider

This block takes one input clock and produces a set of divided clocks. With the default of three stages it gives one half, one quarter and one eighth of the input rate. All outputs come from one shared binary counter and are registered on the same rising edge, so wherever two outputs both rise they rise together. A run input is captured on the falling edge of the input clock. The capture flop acts as the counter's clock enable, so starting or stopping the divider only takes effect at an edge that follows a low phase. The outputs simply hold their levels while stopped, and no shortened high pulse can appear.

A master reset clears every stage at once. It asserts asynchronously and releases through a short synchroniser. Several instances that share the input clock and the reset therefore leave reset on the same edge and run in phase, whatever state each held before. The design is meant for clock generation trees in which related divided clocks must keep their edges aligned.

Top module: `ratio_clock_divider`

## Requirements
- R1: While mreset is high, every bit of div_out is 0. Asserting mreset clears the outputs at once, without waiting for a clock edge.
- R2: After mreset falls, the outputs stay 0 through the first two rising edges of clk_in. The third rising edge, if run was sampled high, drives every bit of div_out to 1.
- R3: Bit k of div_out divides the input rate by 2^(k+1). Over counted edges it stays high for 2^k edges, then low for 2^k edges. Bit 0 toggles on every counted edge. Bit 0 is the /2 output, bit 1 the /4 output and bit 2 the /8 output.
- R4: Every rising edge of bit k+1 of div_out falls on a rising edge of bit k.
- R5: run is sampled only on the falling edge of clk_in. A high level that is present at a rising edge, but was not present at the falling edge before it, does not advance the outputs.
- R6: A rising edge at which the sampled run is low leaves div_out unchanged. When counting resumes, the sequence continues from the held state, with no count lost or added.
- R7: Across any pattern of run changes, every high pulse on bit k of div_out lasts at least 2^k input periods. While run stays high, the rising edges of bit k are exactly 2^(k+1) input periods apart.
- R8: Two instances on the same clk_in and mreset, given the same run after release, drive identical outputs on every cycle, whatever states they held before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| mreset | input | 1 | Master reset: asynchronous assert, synchronised release |
| run | input | 1 | Divider enable, sampled on the falling clock edge |
| div_out | output | STAGES | Divided clocks; bit k is the input divided by 2^(k+1) |

## Verification
The first pattern holds run high continuously after a reset. It checks the release latency, the exact period of each output and the alignment of their rising edges. The second pattern toggles run at random from a fixed seed and compares the outputs with a count of the edges the bench expects to be counted. This tells a correct hold-and-resume apart from a lost or doubled count, and it catches any high pulse shorter than its nominal width. A directed pulse on run that covers only the low half-cycle separates falling-edge sampling from rising-edge sampling. A second instance with a different pre-reset history, reset together with the first, shows whether the shared reset really aligns them.

// File: rtl/ratio_clock_divider.sv
module ratio_clock_divider #(
  parameter int STAGES      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_in,
  input  logic              mreset,
  input  logic              run,
  output logic [STAGES-1:0] div_out
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int;
  logic                   run_q;
  logic [STAGES-1:0]      cnt;

  always_ff @(posedge clk_in or posedge mreset)
    if (mreset) rst_pipe <= '1;
    else        rst_pipe <= rst_pipe << 1;

  assign rst_int = rst_pipe[SYNC_STAGES-1];

  always_ff @(negedge clk_in or posedge mreset)
    if (mreset) run_q <= 1'b0;
    else        run_q <= run;

  always_ff @(posedge clk_in or posedge mreset)
    if (mreset) begin
      cnt     <= '0;
      div_out <= '0;
    end else if (rst_int) begin
      cnt     <= '0;
      div_out <= '0;
    end else if (run_q) begin
      div_out <= ~cnt;
      cnt     <= cnt + 1'b1;
    end

endmodule

// File: rtl/ratio_clock_divider_chk.sv
module ratio_clock_divider_chk #(
  parameter int STAGES = 3
) (
  input logic              clk_in,
  input logic              mreset,
  input logic              run_q,
  input logic              rst_int,
  input logic [STAGES-1:0] div_out
);

  assert_reset_low_R1: assert property (@(posedge clk_in)
    mreset |-> div_out == '0);

  assert_sync_hold_R2: assert property (@(posedge clk_in) disable iff (mreset)
    rst_int |=> div_out == '0);

  assert_lsb_toggle_R3: assert property (@(posedge clk_in) disable iff (mreset)
    (run_q && !rst_int) |=> div_out[0] != $past(div_out[0]));

  assert_wrap_all_high_R3: assert property (@(posedge clk_in) disable iff (mreset)
    (run_q && !rst_int && div_out == '0) |=> div_out == '1);

  assert_freeze_R6: assert property (@(posedge clk_in) disable iff (mreset)
    !run_q |=> $stable(div_out));

  for (genvar k = 0; k < STAGES - 1; k++) begin : g_align
    assert_rise_align_R4: assert property (@(posedge clk_in) disable iff (mreset)
      $rose(div_out[k+1]) |-> $rose(div_out[k]));
  end

endmodule

bind ratio_clock_divider ratio_clock_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk_in  (clk_in),
  .mreset  (mreset),
  .run_q   (run_q),
  .rst_int (rst_int),
  .div_out (div_out)
);

// File: tb/ratio_clock_divider_bench.sv
`timescale 1ns/1ps
module ratio_clock_divider_bench;
  localparam int ST = 3;
  localparam int HALF = 2.5;

  logic clk = 1'b0;
  logic mr  = 1'b1;
  logic en  = 1'b0;
  logic en_p = 1'b0;
  logic [ST-1:0] div, div_p;

  int checks = 0, errors = 0;
  bit done = 0;
  bit steady = 0;
  bit aligned = 0;

  always #2.5 clk = ~clk;

  ratio_clock_divider #(.STAGES(ST)) u_ratio_clock_divider (
    .clk_in(clk), .mreset(mr), .run(en), .div_out(div));
  ratio_clock_divider #(.STAGES(ST)) u_peer (
    .clk_in(clk), .mreset(mr), .run(en_p), .div_out(div_p));

  // expected-value model: counted edges since reset
  logic m_en;
  int   m_rc, m_n;
  always @(negedge clk or posedge mr)
    if (mr) m_en <= 1'b0; else m_en <= en;
  always @(posedge clk or posedge mr)
    if (mr) begin m_rc <= 0; m_n <= 0; end
    else if (m_rc < 2) m_rc <= m_rc + 1;
    else if (m_en) m_n <= m_n + 1;

  function automatic logic exp_bit(int n, int k);
    if (n == 0) return 1'b0;
    return ~(((n - 1) >> k) & 1);
  endfunction

  function automatic logic [ST-1:0] exp_vec(int n);
    logic [ST-1:0] v;
    for (int k = 0; k < ST; k++) v[k] = exp_bit(n, k);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [ST-1:0] act, logic [ST-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, expv);
    end
  endtask

  // sampler, 2 ns after each rising edge
  int cyc = 0;
  int prev_n = 0;
  logic [ST-1:0] prev_div = '0;
  int last_rise [ST];
  int rise_cyc  [ST];
  initial for (int k = 0; k < ST; k++) begin last_rise[k] = -1; rise_cyc[k] = -1; end

  always @(posedge clk) begin
    #2;
    cyc++;
    check(div === exp_vec(m_n), "R3", div, exp_vec(m_n));
    if (mr) check(div === '0, "R1", div, '0);
    if (!mr && m_rc < 2) check(div === '0, "R2", div, '0);
    if (!mr && m_n == 1 && prev_n == 0) check(div === '1, "R2", div, '1);
    if (!mr && !m_en && m_n == prev_n && m_rc == 2)
      check(div === prev_div, "R6", div, prev_div);
    if (aligned) check(div === div_p, "R8", div_p, div);
    for (int k = 0; k < ST; k++) begin
      if (mr || !steady) last_rise[k] = -1;
      if (mr) rise_cyc[k] = -1;
      if (div[k] && !prev_div[k]) begin
        if (steady && last_rise[k] >= 0)
          check(cyc - last_rise[k] == (2 << k), "R7", ST'(cyc - last_rise[k]), ST'(2 << k));
        last_rise[k] = cyc;
        rise_cyc[k]  = cyc;
      end
      if (!div[k] && prev_div[k] && !mr && rise_cyc[k] >= 0)
        check(cyc - rise_cyc[k] >= (1 << k), "R7", ST'(cyc - rise_cyc[k]), ST'(1 << k));
    end
    prev_div = div;
    prev_n   = m_n;
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    void'($urandom(32'h5eed_c10c));
    step(3);
    check(div === '0, "R1 reset state", div, '0);

    // continuous run after release
    en = 1'b1; en_p = 1'b1;
    mr = 1'b0;
    step(3);
    steady = 1;
    step(40);
    steady = 0;

    // random enable toggling, peer gets a different history
    for (int i = 0; i < 300; i++) begin
      en   = 1'($urandom_range(0, 1));
      en_p = 1'($urandom_range(0, 1));
      step(1);
    end

    // R5: high only over the low half-cycle is not sampled
    en = 1'b0; en_p = 1'b0;
    step(2);
    prev_div = div;
    @(negedge clk); #0.5; en = 1'b1;
    @(posedge clk); #0.5; en = 1'b0;
    @(posedge clk); #1.5;
    check(div === prev_div, "R5 low-phase-only pulse ignored", div, prev_div);
    step(1);

    // async reset mid-run aligns both instances
    en = 1'b1; en_p = 1'b1;
    step(5);
    #0.5; mr = 1'b1; #0.5;
    check(div === '0, "R1 async clear", div, '0);
    check(div_p === '0, "R1 async clear peer", div_p, '0);
    step(2);
    mr = 1'b0;
    aligned = 1;
    step(3);
    check(div === '1, "R2 first count all high", div, '1);
    steady = 1;
    step(40);
    steady = 0;
    for (int i = 0; i < 300; i++) begin
      en = 1'($urandom_range(0, 3) != 0);
      en_p = en;
      step(1);
    end
    en = 1'b1; en_p = 1'b1;
    step(3);
    steady = 1;
    step(40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule